// File: doc/BRIEF.md
# Power Path Selector Sequencer

This controller chooses whether the system load is fed from the battery or from the external adapter. It drives two on/off enables, one for the adapter switch and one for the battery switch. It watches two inputs: a sleep flag, and a comparator flag that goes high when the adapter-side supply has sagged to near the battery voltage. All intervals are counted in clock cycles.

At power-up, and for as long as the sleep flag is high, the battery switch is on and the adapter switch is off. When sleep drops, the controller waits through a qualification interval and then opens a dead interval with both switches off. Only after that does it close the adapter switch. The return to the battery is triggered by the proximity comparator or by a new sleep request. It passes through the same both-off dead interval before the battery switch closes again.

The states are BATT, WAIT_QUAL, DEAD_TO_AC, AC and DEAD_TO_BATT. The transitions are:
- BATT to WAIT_QUAL when sleep is low.
- WAIT_QUAL back to BATT when sleep returns.
- WAIT_QUAL to DEAD_TO_AC when qualification expires.
- DEAD_TO_AC to AC when the dead interval expires.
- DEAD_TO_AC to DEAD_TO_BATT on sleep.
- AC to DEAD_TO_BATT on sleep or on the proximity flag.
- DEAD_TO_BATT to BATT when the dead interval expires.

Top module: `pwr_path_seq`

## Requirements
- R1: While reset is low, and in BATT while sleep is high, the battery enable is 1, the adapter enable is 0 and the state code is 0 (BATT).
- R2: In BATT with sleep low, the next state is WAIT_QUAL (code 1), and the battery enable stays 1.
- R3: WAIT_QUAL lasts exactly QUAL_CYC cycles with sleep low, and then moves to DEAD_TO_AC (code 2). The proximity flag is ignored in BATT, WAIT_QUAL and the dead states.
- R4: Sleep going high in WAIT_QUAL returns the controller to BATT. The next exit from sleep needs a full QUAL_CYC again.
- R5: DEAD_TO_AC holds both enables at 0 for exactly DEAD_CYC cycles and then moves to AC (code 3). AC is entered only from DEAD_TO_AC.
- R6: In AC, the adapter enable is 1 and the battery enable is 0. A high proximity flag moves the controller to DEAD_TO_BATT (code 4).
- R7: DEAD_TO_BATT holds both enables at 0 for exactly DEAD_CYC cycles, ignoring sleep, and then moves to BATT. The battery enable rises only out of DEAD_TO_BATT.
- R8: Sleep high in DEAD_TO_AC or in AC moves the controller to DEAD_TO_BATT. The dead count restarts.
- R9: The two enables are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep-mode flag, high = sleep |
| near_batt_i | input | 1 | High when adapter-side supply is within the margin above the battery node |
| ac_en_o | output | 1 | Adapter switch enable |
| batt_en_o | output | 1 | Battery switch enable |
| state_o | output | 3 | Encoded state: 0 BATT, 1 WAIT_QUAL, 2 DEAD_TO_AC, 3 AC, 4 DEAD_TO_BATT |

## Verification
Some properties are checked on every cycle. These are:
- the mutual exclusion of the two enables;
- the single entry path into AC and into a closed battery switch;
- the immediate reactions to sleep and to the proximity flag.

Other properties can only be shown by the bench's scenarios, because they depend on exact cycle counts and histories. These are:
- the exact lengths of the qualification and dead intervals;
- the restart of qualification after an aborted wake-up;
- sleep being ignored during DEAD_TO_BATT;
- an asynchronous reset taken from AC.

// File: rtl/pwr_path_pkg.sv
package pwr_path_pkg;
    typedef enum logic [2:0] {
        ST_BATT         = 3'd0,
        ST_WAIT_QUAL    = 3'd1,
        ST_DEAD_TO_AC   = 3'd2,
        ST_AC           = 3'd3,
        ST_DEAD_TO_BATT = 3'd4
    } pp_state_e;
endpackage

// File: rtl/pps_interval_timer.sv
// Saturating interval counter; done is high in the LIMIT-th cycle after a clear.
module pps_interval_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign done = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr)         cnt_q <= '0;
        else if (en && !done) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pps_drive.sv
// Moore output decode for the switch enables and the state code.
module pps_drive
    import pwr_path_pkg::*;
(
    input  pp_state_e   state,
    output logic        ac_en,
    output logic        batt_en,
    output logic [2:0]  code
);
    always_comb begin
        code = state;
        unique case (state)
            ST_BATT, ST_WAIT_QUAL: begin
                ac_en   = 1'b0;
                batt_en = 1'b1;
            end
            ST_AC: begin
                ac_en   = 1'b1;
                batt_en = 1'b0;
            end
            default: begin // both dead states: break before make
                ac_en   = 1'b0;
                batt_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pwr_path_seq.sv
module pwr_path_seq
    import pwr_path_pkg::*;
#(
    parameter int QUAL_CYC = 6_000_000, // wake-up qualification, clock cycles
    parameter int DEAD_CYC = 2_000      // both-off dead interval, clock cycles
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_i,
    input  logic       near_batt_i,
    output logic       ac_en_o,
    output logic       batt_en_o,
    output logic [2:0] state_o
);
    pp_state_e state_q, state_d;
    logic      state_chg;
    logic      qual_done, dead_done;
    logic      in_dead;

    assign state_chg = (state_d != state_q);
    assign in_dead   = (state_q == ST_DEAD_TO_AC) || (state_q == ST_DEAD_TO_BATT);

    pps_interval_timer #(.LIMIT(QUAL_CYC)) u_qual_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_chg),
        .en   (state_q == ST_WAIT_QUAL),
        .done (qual_done)
    );

    pps_interval_timer #(.LIMIT(DEAD_CYC)) u_dead_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_chg),
        .en   (in_dead),
        .done (dead_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BATT:         if (!sleep_i)       state_d = ST_WAIT_QUAL;
            ST_WAIT_QUAL:    if (sleep_i)        state_d = ST_BATT;          // R4 abort
                             else if (qual_done) state_d = ST_DEAD_TO_AC;    // R3
            ST_DEAD_TO_AC:   if (sleep_i)        state_d = ST_DEAD_TO_BATT;  // R8
                             else if (dead_done) state_d = ST_AC;            // R5
            ST_AC:           if (sleep_i || near_batt_i)
                                                 state_d = ST_DEAD_TO_BATT;  // R6, R8
            ST_DEAD_TO_BATT: if (dead_done)      state_d = ST_BATT;          // R7
            default:                             state_d = ST_DEAD_TO_BATT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BATT;
        else        state_q <= state_d;
    end

    pps_drive u_drive (
        .state  (state_q),
        .ac_en  (ac_en_o),
        .batt_en(batt_en_o),
        .code   (state_o)
    );
endmodule

// File: rtl/pwr_path_seq_chk.sv
module pwr_path_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_i,
    input logic       near_batt_i,
    input logic       ac_en_o,
    input logic       batt_en_o,
    input logic [2:0] state_o
);
    localparam logic [2:0] C_BATT = 3'd0;
    localparam logic [2:0] C_WQ   = 3'd1;
    localparam logic [2:0] C_D2A  = 3'd2;
    localparam logic [2:0] C_AC   = 3'd3;
    localparam logic [2:0] C_D2B  = 3'd4;

    a_r9_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(ac_en_o && batt_en_o));

    a_r1_sleep_holds_batt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == C_BATT && sleep_i) |=> (state_o == C_BATT && batt_en_o && !ac_en_o));

    a_r2_wake_to_qual: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == C_BATT && !sleep_i) |=> (state_o == C_WQ && batt_en_o));

    a_r5_ac_only_from_dead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ac_en_o) |-> ($past(state_o) == C_D2A));

    a_r6_near_leaves_ac: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == C_AC && near_batt_i) |=> (state_o == C_D2B));

    a_r7_batt_only_from_dead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_en_o) |-> ($past(state_o) == C_D2B));

    a_r8_sleep_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == C_D2A || state_o == C_AC) && sleep_i) |=> (state_o == C_D2B));
endmodule

bind pwr_path_seq pwr_path_seq_chk u_chk (.*);

// File: tb/pwr_path_seq_tb.sv
`timescale 1ns/1ps
module pwr_path_seq_tb;
    localparam int QUAL = 4;
    localparam int DEAD = 2;
    localparam int NVEC = 35;
    localparam int WATCHDOG = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_i = 1'b1;
    logic       near_batt_i = 1'b0;
    logic       ac_en_o, batt_en_o;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pwr_path_seq #(.QUAL_CYC(QUAL), .DEAD_CYC(DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .near_batt_i(near_batt_i),
        .ac_en_o(ac_en_o), .batt_en_o(batt_en_o), .state_o(state_o)
    );

    // {sleep, near, expected state after the following edge}
    localparam logic [4:0] VEC [NVEC] = '{
        {2'b10, 3'd0},                                              // R1 sleep holds BATT
        {2'b00, 3'd1}, {2'b01, 3'd1}, {2'b01, 3'd1}, {2'b00, 3'd1}, // R2/R3, near ignored
        {2'b00, 3'd2}, {2'b00, 3'd2},                               // R5 dead interval
        {2'b00, 3'd3}, {2'b00, 3'd3},                               // R6 AC
        {2'b01, 3'd4}, {2'b00, 3'd4},                               // R6 near -> R7
        {2'b10, 3'd0}, {2'b10, 3'd0},                               // R7 back to BATT
        {2'b00, 3'd1}, {2'b00, 3'd1}, {2'b10, 3'd0},                // R4 abort
        {2'b00, 3'd1}, {2'b00, 3'd1}, {2'b00, 3'd1}, {2'b00, 3'd1}, // R4 full restart
        {2'b00, 3'd2},
        {2'b10, 3'd4}, {2'b10, 3'd4}, {2'b10, 3'd0},                // R8 from DEAD_TO_AC
        {2'b00, 3'd1}, {2'b00, 3'd1}, {2'b00, 3'd1}, {2'b00, 3'd1},
        {2'b00, 3'd2}, {2'b00, 3'd2}, {2'b00, 3'd3},
        {2'b10, 3'd4}, {2'b00, 3'd4}, {2'b00, 3'd0},                // R8 from AC, R7 sleep ignored
        {2'b00, 3'd1}
    };

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0:    return "R1";
            3'd1:    return "R3";
            3'd2:    return "R5";
            3'd3:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected enables from the state code (R1, R6, R9)
    task automatic check_state(input string req, input logic [2:0] exp_s);
        check(req, "state", int'(state_o), int'(exp_s));
        check(req, "ac_en", int'(ac_en_o), (exp_s == 3'd3) ? 1 : 0);
        check(req, "batt_en", int'(batt_en_o), (exp_s <= 3'd1) ? 1 : 0);
    endtask

    task automatic step(input logic s, input logic n);
        @(negedge clk);
        sleep_i = s;
        near_batt_i = n;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        sleep_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_state("R1", 3'd0);
        @(negedge clk);
        sleep_i = 1'b1;
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4], VEC[i][3]);
            check_state(tag_of(VEC[i][2:0]), VEC[i][2:0]);
        end

        // Drive to AC, then take an asynchronous reset (R1)
        for (int k = 0; k < 20 && state_o != 3'd3; k++) step(1'b0, 1'b0);
        check_state("R6", 3'd3);
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        check_state("R1", 3'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R3: long sleep with a toggling proximity flag stays on battery
        for (int k = 0; k < 12; k++) begin
            step(1'b1, k[0]);
            check_state("R1", 3'd0);
        end

        // R9: sweep a full cycle, enables never both on
        for (int k = 0; k < 16; k++) begin
            step(1'b0, (k == 12));
            check("R9", "both enables", int'(ac_en_o && batt_en_o), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule